// File: doc/BRIEF.md
# Eight-Level Priority Interrupt Arbiter

This block decides which interrupt an 18-bit accumulator machine takes next. It works across eight priority levels. Level 0 ranks highest and level 7 lowest. Levels 0 to 3 are hardware levels. Each has a group of device request lines and a matching table of per-line vectors. Levels 4 to 7 are software levels. A software level is requested by writing to the arbiter, and it stays requested until it is granted.

Every cycle that carries no command, the arbiter compares the best pending level with the best level already in service. It grants only when the pending level is strictly more urgent. A grant is a one-cycle pulse carrying the level and a vector, and it marks that level as in service.

The processor also drives a small command port with five operations:
- read back the arbiter state;
- load the enable and raise levels;
- test for a skip condition;
- release the most urgent level in service;
- the forced service entry of a system call.

Top module: `prio_irq_arbiter`

## Requirements
- R1: A synchronous active-high `rst` clears the enable, the software requests and the in-service register. While `rst` is high, and in the cycle after it, every output is zero.
- R2: Level n maps to bit value 0x80>>n in both the pending byte and the in-service byte. Command code 0 (read) gives, one cycle later with `rsp_valid`, the following `rsp_data`:
  - bit 17 holds the enable;
  - bit 16 is zero;
  - bits 15:8 hold the pending byte, where hardware bits are the live OR of each level's lines;
  - bits 7:0 hold the in-service byte.
- R3: While the enable is 0, no grant occurs, whatever is pending.
- R4: In a cycle without a command, a grant is issued only when the most urgent pending level has a smaller number than the most urgent in-service level. Any pending level counts when nothing is in service. The granted level is the most urgent pending one.
- R5: A grant appears as a one-cycle `grant_valid` pulse in the cycle after the decision, and it sets the level's in-service bit. A granted software level loses its request. A hardware level's request is never stored: it follows its lines.
- R6: A grant of software level k (4 to 7) carries vector 32 + (k − 4).
- R7: A grant of hardware level h carries the vector of the lowest-numbered asserted line of that level, taken from slot h·LINES+i of `dev_vec`. When that vector is 0, `vec_err` pulses together with the grant.
- R8: Command code 3 (release) clears the in-service bit of the most urgent in-service level only. It does nothing when no level is in service.
- R9: Command code 1 (set) has three effects:
  - it loads the enable from `cmd_ac[17]`;
  - it ORs `cmd_ac[11:8]` into the software requests, where bit 11 is level 4 and bit 8 is level 7;
  - it ORs `cmd_ac[7:0]` into the in-service byte.
- R10: Command code 2 (skip test) returns `rsp_skip`=1 one cycle later when either of these holds:
  - `cmd_ac[17]` and the enable are both 1;
  - `cmd_ac[7:0]`, read as an unsigned number, exceeds the in-service byte.
- R11: Command code 4 (system call) sets the level-4 in-service bit (0x08). Arbitration resumes from the new state on the next command-free cycle.
- R12: No grant is issued in any cycle that carries a command. Codes 5 to 7 return an all-zero response and change nothing. For every command other than read and skip test, `rsp_data` and `rsp_skip` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_req | input | 4*LINES | Device request lines; level h uses bits h*LINES .. h*LINES+LINES-1 |
| dev_vec | input | 4*LINES*VEC_W | Vector per device line, slot h*LINES+i |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 3 | Command code (0 read, 1 set, 2 skip test, 3 release, 4 system call) |
| cmd_ac | input | 18 | Accumulator value supplied with the command |
| grant_valid | output | 1 | One-cycle grant pulse |
| grant_level | output | 3 | Granted level |
| grant_vector | output | VEC_W | Vector of the grant |
| vec_err | output | 1 | Granted hardware vector was zero |
| rsp_valid | output | 1 | Command response valid |
| rsp_data | output | 18 | Read-back word |
| rsp_skip | output | 1 | Skip-test result |

## Verification
A corrupted in-service byte shows at the ports in two ways. It appears as a grant that arrives too early, too late or at the wrong level, at most one cycle after the first command-free cycle that depends on it. It also appears in the next read or skip-test response.

A software request that is lost or that lingers shows the same way:
- a missing vector 32 to 35;
- a repeated one;
- a wrong bit in the read-back pending byte.

A reference model of the levels, fed with the same mixed command and line traffic, compares every output on every clock. A divergence is therefore reported in the cycle it first becomes visible.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    localparam int NLVL        = 8;
    localparam int HW_LVLS     = 4;
    localparam int SW_LVLS     = NLVL - HW_LVLS;
    localparam int WORD_W      = 18;
    localparam int LVL_W       = 3;
    localparam int SW_VEC_BASE = 32;

    typedef enum logic [2:0] {
        OP_READ    = 3'd0,
        OP_SET     = 3'd1,
        OP_SKIP    = 3'd2,
        OP_RELEASE = 3'd3,
        OP_SYSCALL = 3'd4
    } arb_op_e;

    typedef struct packed {
        logic               en;
        logic [SW_LVLS-1:0] sw_req;
        logic [NLVL-1:0]    act;
    } arb_state_t;

    // Mask of a level: level 0 sits in the most significant bit.
    function automatic logic [NLVL-1:0] lvl_mask(input logic [LVL_W-1:0] n);
        return 8'h80 >> n;
    endfunction

    // Most urgent level present in a byte; NLVL when the byte is empty.
    function automatic logic [LVL_W:0] lead_level(input logic [NLVL-1:0] v);
        logic [LVL_W:0] r;
        r = 4'(NLVL);
        for (int n = NLVL - 1; n >= 0; n--) begin
            if (v[NLVL-1-n]) r = 4'(n);
        end
        return r;
    endfunction

endpackage

// File: rtl/irq_hw_scan.sv
module irq_hw_scan #(
    parameter int LINES = 4,
    parameter int VEC_W = 15
) (
    input  logic [LINES-1:0]       lines,
    input  logic [LINES*VEC_W-1:0] vecs,
    output logic                   any,
    output logic [VEC_W-1:0]       vec
);
    // Lowest asserted index wins: scan downward so the last hit is the lowest.
    always_comb begin
        any = 1'b0;
        vec = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (lines[i]) begin
                any = 1'b1;
                vec = vecs[i*VEC_W +: VEC_W];
            end
        end
    end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
    import irq_arb_pkg::*;
(
    input  logic             en,
    input  logic [NLVL-1:0]  pend,
    input  logic [NLVL-1:0]  act,
    output logic             take,
    output logic [LVL_W-1:0] lvl
);
    logic [LVL_W:0] pend_lead;
    logic [LVL_W:0] act_lead;

    always_comb begin
        pend_lead = lead_level(pend);
        act_lead  = lead_level(act);
        // pend_lead < act_lead also implies pend_lead < NLVL.
        take      = en && (pend_lead < act_lead);
        lvl       = pend_lead[LVL_W-1:0];
    end
endmodule

// File: rtl/prio_irq_arbiter.sv
module prio_irq_arbiter
    import irq_arb_pkg::*;
#(
    parameter int LINES = 4,
    parameter int VEC_W = 15
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [HW_LVLS*LINES-1:0]         dev_req,
    input  logic [HW_LVLS*LINES*VEC_W-1:0]   dev_vec,
    input  logic                             cmd_valid,
    input  logic [2:0]                       cmd_op,
    input  logic [WORD_W-1:0]                cmd_ac,
    output logic                             grant_valid,
    output logic [LVL_W-1:0]                 grant_level,
    output logic [VEC_W-1:0]                 grant_vector,
    output logic                             vec_err,
    output logic                             rsp_valid,
    output logic [WORD_W-1:0]                rsp_data,
    output logic                             rsp_skip
);
    localparam int SLOT_BITS = LINES * VEC_W;

    arb_state_t       st, st_nxt;
    logic [HW_LVLS-1:0] hw_any;
    logic [VEC_W-1:0] hw_vec [HW_LVLS];
    logic [NLVL-1:0]  pend;
    logic             take;
    logic [LVL_W-1:0] take_lvl;

    for (genvar g = 0; g < HW_LVLS; g++) begin : g_scan
        irq_hw_scan #(.LINES(LINES), .VEC_W(VEC_W)) u_scan (
            .lines (dev_req[g*LINES +: LINES]),
            .vecs  (dev_vec[g*SLOT_BITS +: SLOT_BITS]),
            .any   (hw_any[g]),
            .vec   (hw_vec[g])
        );
    end

    // Hardware request bits are rebuilt every cycle from the lines.
    always_comb begin
        pend = '0;
        for (int l = 0; l < HW_LVLS; l++) pend[NLVL-1-l] = hw_any[l];
        pend[SW_LVLS-1:0] = st.sw_req;
    end

    irq_prio_pick u_pick (
        .en   (st.en),
        .pend (pend),
        .act  (st.act),
        .take (take),
        .lvl  (take_lvl)
    );

    logic             g_nxt, err_nxt, rv_nxt, sk_nxt;
    logic [VEC_W-1:0] vec_nxt;
    logic [WORD_W-1:0] rd_nxt;
    logic [LVL_W:0]   rel_lvl;
    logic [NLVL-1:0]  gmask;

    always_comb begin
        st_nxt  = st;
        g_nxt   = 1'b0;
        err_nxt = 1'b0;
        vec_nxt = '0;
        rv_nxt  = 1'b0;
        rd_nxt  = '0;
        sk_nxt  = 1'b0;
        rel_lvl = lead_level(st.act);
        gmask   = lvl_mask(take_lvl);
        if (cmd_valid) begin
            rv_nxt = 1'b1;
            case (cmd_op)
                OP_READ:    rd_nxt = {st.en, 1'b0, pend, st.act};
                OP_SET: begin
                    st_nxt.en     = cmd_ac[WORD_W-1];
                    st_nxt.sw_req = st.sw_req | cmd_ac[11:8];
                    st_nxt.act    = st.act | cmd_ac[7:0];
                end
                OP_SKIP:    sk_nxt = (cmd_ac[WORD_W-1] && st.en) || (cmd_ac[7:0] > st.act);
                OP_RELEASE: if (rel_lvl != 4'(NLVL))
                                st_nxt.act = st.act & ~lvl_mask(rel_lvl[LVL_W-1:0]);
                OP_SYSCALL: st_nxt.act = st.act | lvl_mask(3'd4);
                default: ;
            endcase
        end else if (take) begin
            g_nxt      = 1'b1;
            st_nxt.act = st.act | gmask;
            if (take_lvl[2]) begin
                st_nxt.sw_req = st.sw_req & ~gmask[SW_LVLS-1:0];
                vec_nxt       = VEC_W'(SW_VEC_BASE) + VEC_W'(take_lvl[1:0]);
            end else begin
                vec_nxt = hw_vec[take_lvl[1:0]];
            end
            err_nxt = (vec_nxt == '0);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st           <= '0;
            grant_valid  <= 1'b0;
            grant_level  <= '0;
            grant_vector <= '0;
            vec_err      <= 1'b0;
            rsp_valid    <= 1'b0;
            rsp_data     <= '0;
            rsp_skip     <= 1'b0;
        end else begin
            st           <= st_nxt;
            grant_valid  <= g_nxt;
            grant_level  <= g_nxt ? take_lvl : '0;
            grant_vector <= vec_nxt;
            vec_err      <= err_nxt;
            rsp_valid    <= rv_nxt;
            rsp_data     <= rd_nxt;
            rsp_skip     <= sk_nxt;
        end
    end

    // ---------------- assertions ----------------
    p_no_grant_on_cmd_r12: assert property (@(posedge clk) disable iff (rst)
        grant_valid |-> !$past(cmd_valid));

    p_grant_needs_en_r3: assert property (@(posedge clk) disable iff (rst)
        grant_valid |-> $past(st.en));

    p_grant_outranks_r4: assert property (@(posedge clk) disable iff (rst)
        grant_valid |-> (4'(grant_level) < lead_level($past(st.act))));

    p_grant_marks_active_r5: assert property (@(posedge clk) disable iff (rst)
        grant_valid |-> ((st.act & lvl_mask(grant_level)) != '0));

    p_grant_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        grant_valid |=> !grant_valid || (grant_level != $past(grant_level)));

    p_sw_vector_r6: assert property (@(posedge clk) disable iff (rst)
        (grant_valid && grant_level[2]) |->
            (grant_vector == VEC_W'(SW_VEC_BASE) + VEC_W'(grant_level[1:0])));

    p_release_one_r8: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && $past(cmd_op) == OP_RELEASE && $past(st.act) != '0) |->
            ($countones(st.act) == $countones($past(st.act)) - 1));

    p_syscall_r11: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && $past(cmd_op) == OP_SYSCALL) |-> st.act[3]);

endmodule

// File: tb/prio_irq_arbiter_test.sv
module prio_irq_arbiter_test;
    localparam int LINES = 4;
    localparam int VEC_W = 15;

    logic clk = 1'b0;
    logic rst;
    logic [4*LINES-1:0]       dev_req;
    logic [4*LINES*VEC_W-1:0] dev_vec;
    logic        cmd_valid;
    logic [2:0]  cmd_op;
    logic [17:0] cmd_ac;
    logic        grant_valid, vec_err, rsp_valid, rsp_skip;
    logic [2:0]  grant_level;
    logic [VEC_W-1:0] grant_vector;
    logic [17:0] rsp_data;

    always #10 clk = ~clk;

    prio_irq_arbiter #(.LINES(LINES), .VEC_W(VEC_W)) uut (
        .clk(clk), .rst(rst), .dev_req(dev_req), .dev_vec(dev_vec),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_ac(cmd_ac),
        .grant_valid(grant_valid), .grant_level(grant_level),
        .grant_vector(grant_vector), .vec_err(vec_err),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_skip(rsp_skip));

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string tag = "R1";

    // Behavioural reference state
    int m_en, m_sw, m_act;
    int e_gv, e_gl, e_gvec, e_err, e_rv, e_rd, e_sk;

    function automatic int vt(int l, int i);
        if (l == 2 && i == 1) return 0;   // zero vector slot for R7
        return 100 + 7 * (l * LINES + i);
    endfunction

    function automatic int lead(int v);
        for (int n = 0; n < 8; n++) if ((v & (128 >> n)) != 0) return n;
        return 8;
    endfunction

    task automatic model();
        int hw, pend, g, a;
        hw = 0;
        for (int l = 0; l < 4; l++)
            for (int i = 0; i < LINES; i++)
                if (dev_req[l*LINES+i]) hw |= (128 >> l);
        pend = hw | m_sw;
        e_gv = 0; e_gl = 0; e_gvec = 0; e_err = 0; e_rv = 0; e_rd = 0; e_sk = 0;
        if (rst) begin
            m_en = 0; m_sw = 0; m_act = 0;
        end else if (cmd_valid) begin
            e_rv = 1;
            case (int'(cmd_op))
                0: e_rd = (m_en << 17) | (pend << 8) | m_act;
                1: begin
                    m_en  = (int'(cmd_ac) >> 17) & 1;
                    m_sw  |= (int'(cmd_ac) >> 8) & 15;
                    m_act |= int'(cmd_ac) & 255;
                end
                2: e_sk = ((((int'(cmd_ac) >> 17) & 1) == 1 && m_en == 1) ||
                           ((int'(cmd_ac) & 255) > m_act)) ? 1 : 0;
                3: begin
                    a = lead(m_act);
                    if (a < 8) m_act &= ~(128 >> a);
                end
                4: m_act |= 8;
                default: ;
            endcase
        end else if (m_en == 1 && lead(pend) < lead(m_act)) begin
            g = lead(pend);
            e_gv = 1; e_gl = g;
            m_act |= (128 >> g);
            if (g >= 4) begin
                e_gvec = 32 + g - 4;
                m_sw &= ~(128 >> g);
            end else begin
                for (int i = LINES - 1; i >= 0; i--)
                    if (dev_req[g*LINES+i]) e_gvec = vt(g, i);
            end
            e_err = (e_gvec == 0) ? 1 : 0;
        end
    endtask

    task automatic chk(string field, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", tag, field, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model();
        @(negedge clk);
        chk("grant_valid R5", int'(grant_valid), e_gv);
        chk("grant_level R4", int'(grant_level), e_gl);
        chk("grant_vector R6/R7", int'(grant_vector), e_gvec);
        chk("vec_err R7", int'(vec_err), e_err);
        chk("rsp_valid R12", int'(rsp_valid), e_rv);
        chk("rsp_data R2", int'(rsp_data), e_rd);
        chk("rsp_skip R10", int'(rsp_skip), e_sk);
    endtask

    task automatic idle(int n);
        cmd_valid = 0; cmd_op = 0; cmd_ac = 0;
        for (int k = 0; k < n; k++) tick();
    endtask

    task automatic cmd(int op, int ac);
        cmd_valid = 1; cmd_op = 3'(op); cmd_ac = 18'(ac);
        tick();
        cmd_valid = 0; cmd_op = 0; cmd_ac = 0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got hang expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int lf;
        rst = 1; dev_req = '0; cmd_valid = 0; cmd_op = 0; cmd_ac = 0;
        for (int l = 0; l < 4; l++)
            for (int i = 0; i < LINES; i++)
                dev_vec[(l*LINES+i)*VEC_W +: VEC_W] = VEC_W'(vt(l, i));
        m_en = 0; m_sw = 0; m_act = 0;
        // R1: reset state
        tag = "R1";
        tick(); tick();
        rst = 0;
        cmd(0, 0);
        idle(1);
        // R3: requests pending while disabled
        tag = "R3";
        dev_req[1*LINES+0] = 1'b1;
        idle(3);
        tag = "R2";
        cmd(0, 0);
        // R9: enable plus software requests for levels 5 and 7
        tag = "R9";
        cmd(1, (1 << 17) | (4'b0101 << 8));
        tag = "R4";
        idle(3);
        tag = "R2";
        cmd(0, 0);
        // R8: releases walk down the in-service levels
        tag = "R8";
        cmd(3, 0); idle(2);
        cmd(3, 0); idle(2);
        cmd(3, 0); idle(2);
        cmd(0, 0);
        // R7: level 2 lowest line has zero vector; level 0 lines 2,3
        tag = "R7";
        dev_req = '0;
        dev_req[2*LINES+1] = 1'b1; dev_req[2*LINES+3] = 1'b1;
        idle(2);
        dev_req[0*LINES+2] = 1'b1; dev_req[0*LINES+3] = 1'b1;
        idle(2);
        cmd(3, 0); cmd(3, 0); idle(2);
        // R5: hardware request follows lines; software request cleared
        tag = "R5";
        dev_req = '0;
        cmd(3, 0); cmd(3, 0); cmd(3, 0); cmd(3, 0);
        cmd(0, 0);
        cmd(1, (1 << 17) | (4'b1000 << 8));
        idle(2);
        cmd(0, 0);
        // R10: skip tests
        tag = "R10";
        cmd(2, 1 << 17);
        cmd(2, 0);
        cmd(2, 255);
        cmd(2, 8);
        cmd(1, 0);          // enable off
        cmd(2, 1 << 17);
        // R11: system call
        tag = "R11";
        cmd(4, 0);
        cmd(0, 0);
        // R12: commands every cycle block grants; undefined codes
        tag = "R12";
        cmd(3, 0); cmd(3, 0);
        cmd(1, (1 << 17) | (4'b1111 << 8));
        dev_req[3*LINES+2] = 1'b1;
        cmd(6, 0); cmd(7, 3); cmd(5, 0); cmd(0, 0);
        idle(6);
        // R4: mixed traffic
        tag = "R4";
        lf = 32'h1234_5677;
        for (int k = 0; k < 600; k++) begin
            lf = lf * 1103515245 + 12345;
            if (((lf >> 8) & 7) == 0) dev_req = 16'((lf >> 12) & ((lf >> 16) | (lf >> 20)));
            if (((lf >> 4) & 3) == 0) begin
                case ((lf >> 24) & 7)
                    0, 1, 2: cmd(3, 0);
                    3: cmd(1, (((lf >> 28) & 3) != 0 ? (1 << 17) : 0) | (((lf >> 10) & 15) << 8)
                              | ((((lf >> 6) & 7) == 0) ? ((lf >> 14) & 255) : 0));
                    4: cmd(2, (lf >> 9) & 18'h3FFFF);
                    5: cmd(4, 0);
                    default: cmd(0, 0);
                endcase
            end else begin
                idle(1);
            end
        end
        // R1: reset mid-run clears state
        tag = "R1";
        rst = 1; idle(1); rst = 0;
        dev_req = '0;
        cmd(0, 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule